// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of device interrupt request lines and applies a per-line mask. It picks the most urgent pending request and raises a single interrupt line to the processor. It then answers the processor's acknowledge handshake by supplying a vector number. The processor acknowledges with two low pulses on an active-low acknowledge input. The first pulse moves the winning request into service and lets the interrupt line fall. During the second pulse the controller drives the vector, which is a programmable base plus the line number, onto an 8-bit bus with an enable.

Requests are captured on the rising edge of a line, so a line held high counts as one request. A line stays in service until software writes an end-of-interrupt command. While a line is in service, it blocks every line of equal or lower urgency. If the request that raised the interrupt is gone by the time of the first pulse, the controller still completes the handshake and supplies a spurious vector.

Top module: `vpic`

## Requirements
- R1: After reset the interrupt output is low, the vector enable is low, the vector bus reads 0, all lines are unmasked and the vector base is 32.
- R2: A low-to-high transition on an unmasked, unblocked request line sets it pending, and the interrupt output is high in the cycle after the clock edge that samples the new level.
- R3: A line whose mask bit is 1 never raises the interrupt output. Its request stays pending, and clearing the mask bit later raises the interrupt output.
- R4: When several eligible requests are pending, the lowest line number wins.
- R5: The first falling edge of the acknowledge input drops the interrupt output and moves the winning line from pending to in-service.
- R6: After the second falling edge of the acknowledge input, the vector enable is high and the bus carries the vector for as long as acknowledge stays low. Both return to 0 once acknowledge goes high.
- R7: The vector equals base plus line number, modulo 256. The base defaults to 32 and is set by a write with select 1.
- R8: While a line is in service, requests on that line and on higher-numbered lines do not raise the interrupt output. Lower-numbered lines still do.
- R9: A write with select 2 (end of interrupt) clears the lowest-numbered in-service bit only. A write with select 0 loads the mask, with bit i masking line i.
- R10: If no eligible request exists at the first acknowledge edge, no line enters service and the vector supplied is base plus 7.
- R11: A request line held high after its request has been serviced raises no further interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N_IRQ | Device request lines, rising-edge captured |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 mask, 1 base, 2 end of interrupt, 3 no effect |
| wr_data | input | 8 | Write data |
| int_o | output | 1 | Interrupt request to processor |
| inta_n | input | 1 | Active-low acknowledge from processor |
| vec_o | output | 8 | Vector number, 0 when not enabled |
| vec_oe | output | 1 | Vector bus enable |

## Verification
A wrong pending or in-service bit shows up at the ports one cycle later. It appears as an interrupt that rises when it should stay quiet, or that stays low when it should rise. It can also appear as a wrong line number inside the vector on the next second acknowledge pulse. A lost in-service bit is harder to see, because nothing happens until a lower-urgency request should have been held back. The bench therefore interleaves nested requests with end-of-interrupt writes, and it compares the interrupt, enable and vector against a behavioural model on every clock, so any divergence is caught in the cycle it first appears.

// File: rtl/vpic.sv
module vpic #(
  parameter int N_IRQ    = 8,
  parameter int VW       = 8,
  parameter int DEF_BASE = 32,
  parameter int SPUR_OFS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [VW-1:0]    wr_data,
  output logic             int_o,
  input  logic             inta_n,
  output logic [VW-1:0]    vec_o,
  output logic             vec_oe
);
  localparam int IW = $clog2(N_IRQ);
  localparam logic [1:0] IDLE = 2'd0, ACK1 = 2'd1, GAP = 2'd2, ACK2 = 2'd3;

  logic [N_IRQ-1:0] irq_q, pend, mask, isr;
  logic [VW-1:0]    base;
  logic [IW-1:0]    sel, win;
  logic [1:0]       ph;
  logic             inta_q, spur, hit, blk;

  always_comb begin
    blk = 1'b0;
    hit = 1'b0;
    win = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      blk = blk | isr[i];
      if (!blk && pend[i] && !mask[i] && !hit) begin
        hit = 1'b1;
        win = IW'(i);
      end
    end
  end

  wire              fall    = inta_q & ~inta_n;
  wire              rise    = ~inta_q & inta_n;
  wire              take    = (ph == IDLE) && fall && hit;
  wire              eoi     = wr_en && (wr_sel == 2'd2);
  wire [N_IRQ-1:0]  win_bit = take ? (N_IRQ'(1) << win) : '0;
  wire [N_IRQ-1:0]  eoi_bit = eoi ? (isr & (~isr + 1'b1)) : '0;

  assign int_o  = (ph == IDLE) && hit;
  assign vec_oe = (ph == ACK2);
  assign vec_o  = vec_oe ? base + (spur ? VW'(SPUR_OFS) : VW'(sel)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend   <= '0;
      mask   <= '0;
      isr    <= '0;
      base   <= VW'(DEF_BASE);
      sel    <= '0;
      spur   <= 1'b0;
      ph     <= IDLE;
      inta_q <= 1'b1;
    end else begin
      irq_q  <= irq_i;
      inta_q <= inta_n;
      pend   <= (pend | (irq_i & ~irq_q)) & ~win_bit;
      isr    <= (isr & ~eoi_bit) | win_bit;
      if (wr_en && wr_sel == 2'd0) mask <= wr_data[N_IRQ-1:0];
      if (wr_en && wr_sel == 2'd1) base <= wr_data;
      case (ph)
        IDLE: if (fall) begin
          ph   <= ACK1;
          spur <= ~hit;
          if (hit) sel <= win;
        end
        ACK1: if (rise) ph <= GAP;
        GAP:  if (fall) ph <= ACK2;
        default: if (rise) ph <= IDLE;
      endcase
    end
  end

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> |(pend & ~mask));
  // R5
  int_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !int_o);
  // R5
  take_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eoi) |=> $countones(isr) == $past($countones(isr)) + 1);
  // R6
  vec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> $past(!inta_n));
  // R9
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && |isr && !take) |=> $countones(isr) == $past($countones(isr)) - 1);
endmodule

// File: tb/sim_vpic.sv
module sim_vpic;
  logic       clk = 0, rst_n = 0, wr_en = 0, inta_n = 1;
  logic [7:0] irq = 0, wr_data = 0;
  logic [1:0] wr_sel = 0;
  logic       int_o, vec_oe;
  logic [7:0] vec_o;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vpic u0 (.clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en(wr_en), .wr_sel(wr_sel),
           .wr_data(wr_data), .int_o(int_o), .inta_n(inta_n), .vec_o(vec_o), .vec_oe(vec_oe));

  // behavioural reference
  bit [7:0] m_pend, m_isr, m_mask, m_irqq;
  int m_base = 32, m_ph = 0, m_sel = 0;
  bit m_spur, m_intaq = 1;

  function automatic int m_win();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return -1;
      if (m_pend[i] && !m_mask[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_isr = 0; m_mask = 0; m_irqq = 0;
      m_base = 32; m_ph = 0; m_sel = 0; m_spur = 0; m_intaq = 1;
    end else begin
      int w, clr;
      bit fl, rs;
      w = m_win();
      fl = m_intaq && !inta_n;
      rs = !m_intaq && inta_n;
      clr = -1;
      if (wr_en && wr_sel == 2)
        for (int i = 7; i >= 0; i--) if (m_isr[i]) clr = i;
      m_pend = m_pend | (irq & ~m_irqq);
      if (clr >= 0) m_isr[clr] = 0;
      case (m_ph)
        0: if (fl) begin
             m_ph = 1;
             m_spur = (w < 0);
             if (w >= 0) begin m_sel = w; m_isr[w] = 1; m_pend[w] = 0; end
           end
        1: if (rs) m_ph = 2;
        2: if (fl) m_ph = 3;
        default: if (rs) m_ph = 0;
      endcase
      if (wr_en && wr_sel == 0) m_mask = wr_data;
      if (wr_en && wr_sel == 1) m_base = wr_data;
      m_irqq = irq;
      m_intaq = inta_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int ev;
    ev = (m_ph == 3) ? ((m_base + (m_spur ? 7 : m_sel)) % 256) : 0;
    chk(int_o == (m_ph == 0 && m_win() >= 0), "R2 model int", int_o, m_ph == 0 && m_win() >= 0);
    chk(vec_oe == (m_ph == 3), "R6 model oe", vec_oe, m_ph == 3);
    chk(vec_o == ev, "R7 model vec", vec_o, ev);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int s, input int d);
    wr_en = 1; wr_sel = 2'(s); wr_data = 8'(d);
    step(1);
    wr_en = 0;
  endtask

  task automatic ack(input int expv, input string tag);
    inta_n = 0; step(1);
    chk(int_o == 0, "R5 int drop", int_o, 0);
    step(1); inta_n = 1; step(2);
    inta_n = 0; step(1);
    chk(vec_oe == 1 && vec_o == 8'(expv), tag, vec_o, expv);
    step(1);
    chk(vec_oe == 1 && vec_o == 8'(expv), tag, vec_o, expv);
    inta_n = 1; step(1);
    chk(vec_oe == 0 && vec_o == 0, "R6 release", vec_o, 0);
  endtask

  initial begin
    step(3);
    chk(int_o == 0 && vec_oe == 0 && vec_o == 0, "R1 reset", int_o, 0);
    rst_n = 1; step(1);
    chk(int_o == 0, "R1 idle", int_o, 0);
    // R2, R7 default base
    irq[3] = 1; step(1);
    chk(int_o == 1, "R2 raise", int_o, 1);
    ack(35, "R7 default vec");
    chk(int_o == 0, "R8 self blocked", int_o, 0);
    wr(2, 0); step(1);
    // R11 line 3 still high
    step(3);
    chk(int_o == 0, "R11 held level", int_o, 0);
    // R3 masking
    wr(0, 8'h20);
    irq[5] = 1; step(3);
    chk(int_o == 0, "R3 masked", int_o, 0);
    wr(0, 0);
    chk(int_o == 1, "R3 unmask", int_o, 1);
    ack(37, "R6 vector line5");
    wr(2, 0);
    irq = 0; step(2);
    // R4 priority, R8 nesting, R9 eoi
    irq[6] = 1; irq[1] = 1; step(1);
    ack(33, "R4 lowest wins");
    step(2);
    chk(int_o == 0, "R8 lower held", int_o, 0);
    irq[0] = 1; step(1);
    chk(int_o == 1, "R8 higher passes", int_o, 1);
    ack(32, "R8 nested vec");
    wr(2, 0); step(1);
    chk(int_o == 0, "R9 clears only line0", int_o, 0);
    wr(2, 0);
    chk(int_o == 1, "R9 line1 cleared", int_o, 1);
    ack(38, "R4 line6 vec");
    wr(2, 0);
    irq = 0; step(2);
    // R7 base write
    wr(1, 8'h40);
    irq[4] = 1; step(1);
    ack(8'h44, "R7 new base");
    wr(2, 0);
    irq = 0; step(2);
    // R10 spurious
    irq[2] = 1; step(1);
    chk(int_o == 1, "R10 pre", int_o, 1);
    wr(0, 8'h04);
    chk(int_o == 0, "R3 masked after raise", int_o, 0);
    ack(8'h47, "R10 spurious vec");
    wr(0, 0);
    chk(int_o == 1, "R10 still pending", int_o, 1);
    ack(8'h42, "R10 later vec");
    wr(3, 8'hFF); step(1);
    chk(int_o == 0, "R9 select3 no effect", int_o, 0);
    wr(2, 0); step(3);
    chk(int_o == 0, "R11 final", int_o, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule